// File: doc/BRIEF.md
# Scalar-Vector Memory Ordering Stall Unit

This unit keeps memory operations in order within one instruction stream when a scalar core and a single vector memory unit reach memory by separate paths. Each unit reports a one-cycle pulse when it issues a memory operation and another when that operation commits. The unit keeps a running count of unfinished operations for each side. For register-targeted ordering, it also keeps a pending flag and the tag of the newest operation for every vector register.

When fetch presents an ordering instruction, the unit reads its kind and, where it applies, a vector register number. It raises `stall` while the operations that must finish first are still outstanding. Kinds that need no wait on this machine pass without any stall, because it has one vector memory path and no vector cache. Fetch holds while `stall` is high and resumes once it falls.

Top module: `mem_sync_ctrl`

## Requirements
- R1: After reset, `stall` is low, both outstanding counts are zero and every per-register pending flag is clear.
- R2: Each outstanding count rises by one on an issue pulse and falls by one on a commit pulse. An issue and a commit in the same cycle leave it unchanged. A commit while the count is zero leaves it at zero. An issue at the largest count value leaves it there.
- R3: Kind code 0 (scalar waits on vector): if the vector count is nonzero when the request is seen, `stall` is high from the next clock edge. It falls at the first edge after the vector count has become zero.
- R4: Kind code 1 (vector waits on scalar) behaves like R3, but watches the scalar count.
- R5: Kind codes 2 (vector after vector) and 3 (lane after lane) never raise `stall`. Neither do the unused codes 6 and 7.
- R6: A request whose watched count or pending flag is already clear when it is seen does not raise `stall`. `stall` only rises at the edge that follows a request.
- R7: Kind code 4 (scalar waits on one vector register) waits only on the vector pending flag of `sync_vreg`. It releases at the edge after that flag clears, even if other vector operations are still outstanding.
- R8: Kind code 5 (vector waits on scalar writes to one vector register) behaves like R7, but uses the scalar-side pending flags.
- R9: A commit clears a register's pending flag only if its register and tag match the newest issue to that register. A commit that carries an older tag leaves the flag set.
- R10: While `stall` is high, further requests are ignored. Issues and commits keep updating the counts and flags, and an issue during a stall lengthens a full-drain wait.
- R11: An issue and a commit to the same register in the same cycle leave that register's flag set, with the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_issue | input | 1 | Scalar memory operation issued |
| s_issue_vreg | input | 5 | Vector register the scalar operation targets |
| s_issue_tag | input | 4 | Tag of the issued scalar operation |
| s_commit | input | 1 | Scalar memory operation committed |
| s_commit_vreg | input | 5 | Register of the committed scalar operation |
| s_commit_tag | input | 4 | Tag of the committed scalar operation |
| v_issue | input | 1 | Vector memory operation issued |
| v_issue_vreg | input | 5 | Vector register of the issued operation |
| v_issue_tag | input | 4 | Tag of the issued vector operation |
| v_commit | input | 1 | Vector memory operation committed |
| v_commit_vreg | input | 5 | Register of the committed vector operation |
| v_commit_tag | input | 4 | Tag of the committed vector operation |
| sync_req | input | 1 | Ordering instruction presented by fetch |
| sync_kind | input | 3 | Ordering kind code (0..5 used) |
| sync_vreg | input | 5 | Vector register for kinds 4 and 5 |
| stall | output | 1 | Hold fetch |

## Verification
Every stimulus goes in at a falling edge and is consumed at the next rising edge. Because `stall` is a register, its response to a request can be read at the following falling edge, one cycle later. A release takes two edges: the commit that empties a count or clears a flag lands at one edge, and `stall` falls only at the edge after that. The directed tasks therefore check that `stall` is still high in the cycle the drain completes, and low one cycle later. A request made while the unit is stalling is judged by whether `stall` stays low once the current wait ends.

// File: rtl/sync_pkg.sv
package sync_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_SAV     = 3'd0,
    K_VAS     = 3'd1,
    K_VAV     = 3'd2,
    K_VPVP    = 3'd3,
    K_SAV_REG = 3'd4,
    K_VAS_REG = 3'd5
  } sync_kind_e;

  localparam int UNIT_S = 0;
  localparam int UNIT_V = 1;
  localparam int NUM_UNITS = 2;
endpackage

// File: rtl/op_counter.sv
module op_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      unique case ({inc, dec})
        2'b10:   if (cnt != MAXV) cnt <= cnt + 1'b1;
        2'b01:   if (cnt != '0)   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/vreg_tracker.sv
module vreg_tracker #(
  parameter int NUM_VREG = 32,
  parameter int VREG_W   = 5,
  parameter int TAG_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                issue,
  input  logic [VREG_W-1:0]   issue_vreg,
  input  logic [TAG_W-1:0]    issue_tag,
  input  logic                commit,
  input  logic [VREG_W-1:0]   commit_vreg,
  input  logic [TAG_W-1:0]    commit_tag,
  output logic [NUM_VREG-1:0] pend
);
  logic [TAG_W-1:0]    tag_mem [NUM_VREG];
  logic [NUM_VREG-1:0] pend_d;

  // newest tag per register; one write port, no reset
  always_ff @(posedge clk) begin
    if (issue) tag_mem[issue_vreg] <= issue_tag;
  end

  always_comb begin
    pend_d = pend;
    for (int i = 0; i < NUM_VREG; i++) begin
      if (commit && commit_vreg == VREG_W'(i) && tag_mem[i] == commit_tag)
        pend_d[i] = 1'b0;
      // a fresh issue outranks a same-cycle commit
      if (issue && issue_vreg == VREG_W'(i))
        pend_d[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pend_d;
  end
endmodule

// File: rtl/sync_decide.sv
module sync_decide
  import sync_pkg::*;
#(
  parameter int NUM_VREG = 32,
  parameter int VREG_W   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sync_req,
  input  logic [KIND_W-1:0]   sync_kind,
  input  logic [VREG_W-1:0]   sync_vreg,
  input  logic                s_zero,
  input  logic                v_zero,
  input  logic [NUM_VREG-1:0] s_pend,
  input  logic [NUM_VREG-1:0] v_pend,
  output logic                stall,
  output logic [KIND_W-1:0]   held_kind
);
  logic [VREG_W-1:0] held_vreg;
  logic              busy_new, busy_held;

  function automatic logic must_wait(
    input logic [KIND_W-1:0]   k,
    input logic [VREG_W-1:0]   r,
    input logic                sz,
    input logic                vz,
    input logic [NUM_VREG-1:0] sp,
    input logic [NUM_VREG-1:0] vp
  );
    case (sync_kind_e'(k))
      K_SAV:     must_wait = !vz;
      K_VAS:     must_wait = !sz;
      K_SAV_REG: must_wait = vp[r];
      K_VAS_REG: must_wait = sp[r];
      default:   must_wait = 1'b0;
    endcase
  endfunction

  always_comb begin
    busy_new  = must_wait(sync_kind, sync_vreg, s_zero, v_zero, s_pend, v_pend);
    busy_held = must_wait(held_kind, held_vreg, s_zero, v_zero, s_pend, v_pend);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stall     <= 1'b0;
      held_kind <= '0;
      held_vreg <= '0;
    end else if (stall) begin
      if (!busy_held) stall <= 1'b0;
    end else if (sync_req && busy_new) begin
      stall     <= 1'b1;
      held_kind <= sync_kind;
      held_vreg <= sync_vreg;
    end
  end
endmodule

// File: rtl/mem_sync_ctrl.sv
module mem_sync_ctrl
  import sync_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int NUM_VREG = 32,
  parameter int TAG_W    = 4,
  localparam int VREG_W  = $clog2(NUM_VREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_issue,
  input  logic [VREG_W-1:0] s_issue_vreg,
  input  logic [TAG_W-1:0]  s_issue_tag,
  input  logic              s_commit,
  input  logic [VREG_W-1:0] s_commit_vreg,
  input  logic [TAG_W-1:0]  s_commit_tag,
  input  logic              v_issue,
  input  logic [VREG_W-1:0] v_issue_vreg,
  input  logic [TAG_W-1:0]  v_issue_tag,
  input  logic              v_commit,
  input  logic [VREG_W-1:0] v_commit_vreg,
  input  logic [TAG_W-1:0]  v_commit_tag,
  input  logic              sync_req,
  input  logic [KIND_W-1:0] sync_kind,
  input  logic [VREG_W-1:0] sync_vreg,
  output logic              stall
);
  logic [NUM_UNITS-1:0]    u_issue, u_commit, u_zero;
  logic [VREG_W-1:0]       u_issue_vreg  [NUM_UNITS];
  logic [VREG_W-1:0]       u_commit_vreg [NUM_UNITS];
  logic [TAG_W-1:0]        u_issue_tag   [NUM_UNITS];
  logic [TAG_W-1:0]        u_commit_tag  [NUM_UNITS];
  logic [CNT_W-1:0]        u_cnt         [NUM_UNITS];
  logic [NUM_VREG-1:0]     u_pend        [NUM_UNITS];
  logic [CNT_W-1:0]        s_cnt, v_cnt;
  logic [KIND_W-1:0]       held_kind;

  always_comb begin
    u_issue[UNIT_S]       = s_issue;
    u_commit[UNIT_S]      = s_commit;
    u_issue_vreg[UNIT_S]  = s_issue_vreg;
    u_commit_vreg[UNIT_S] = s_commit_vreg;
    u_issue_tag[UNIT_S]   = s_issue_tag;
    u_commit_tag[UNIT_S]  = s_commit_tag;
    u_issue[UNIT_V]       = v_issue;
    u_commit[UNIT_V]      = v_commit;
    u_issue_vreg[UNIT_V]  = v_issue_vreg;
    u_commit_vreg[UNIT_V] = v_commit_vreg;
    u_issue_tag[UNIT_V]   = v_issue_tag;
    u_commit_tag[UNIT_V]  = v_commit_tag;
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    op_counter #(.CNT_W(CNT_W)) u_cnt_i (
      .clk(clk), .rst(rst),
      .inc(u_issue[u]), .dec(u_commit[u]),
      .cnt(u_cnt[u]), .zero(u_zero[u])
    );

    vreg_tracker #(.NUM_VREG(NUM_VREG), .VREG_W(VREG_W), .TAG_W(TAG_W)) u_trk (
      .clk(clk), .rst(rst),
      .issue(u_issue[u]), .issue_vreg(u_issue_vreg[u]), .issue_tag(u_issue_tag[u]),
      .commit(u_commit[u]), .commit_vreg(u_commit_vreg[u]), .commit_tag(u_commit_tag[u]),
      .pend(u_pend[u])
    );
  end

  assign s_cnt = u_cnt[UNIT_S];
  assign v_cnt = u_cnt[UNIT_V];

  sync_decide #(.NUM_VREG(NUM_VREG), .VREG_W(VREG_W)) u_dec (
    .clk(clk), .rst(rst),
    .sync_req(sync_req), .sync_kind(sync_kind), .sync_vreg(sync_vreg),
    .s_zero(u_zero[UNIT_S]), .v_zero(u_zero[UNIT_V]),
    .s_pend(u_pend[UNIT_S]), .v_pend(u_pend[UNIT_V]),
    .stall(stall), .held_kind(held_kind)
  );
endmodule

// File: rtl/mem_sync_ctrl_chk.sv
module mem_sync_ctrl_chk
  import sync_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic              sync_req,
  input logic [KIND_W-1:0] sync_kind,
  input logic [KIND_W-1:0] held_kind,
  input logic              s_issue,
  input logic              s_commit,
  input logic              v_issue,
  input logic              v_commit,
  input logic [CNT_W-1:0]  s_cnt,
  input logic [CNT_W-1:0]  v_cnt
);
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (rst)
    (s_cnt == '0 && s_commit && !s_issue) |=> (s_cnt == '0));

  assert_balanced_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (v_issue && v_commit) |=> $stable(v_cnt));

  assert_sav_release_R3: assert property (@(posedge clk) disable iff (rst)
    (stall && held_kind == K_SAV && v_cnt == '0) |=> !stall);

  assert_vas_release_R4: assert property (@(posedge clk) disable iff (rst)
    (stall && held_kind == K_VAS && s_cnt == '0) |=> !stall);

  assert_free_kinds_R5: assert property (@(posedge clk) disable iff (rst)
    (!stall && sync_req && (sync_kind == K_VAV || sync_kind == K_VPVP)) |=> !stall);

  assert_stall_from_req_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |-> $past(sync_req));

  assert_req_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (stall && sync_req) |=> $stable(held_kind));
endmodule

bind mem_sync_ctrl mem_sync_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .stall(stall),
  .sync_req(sync_req), .sync_kind(sync_kind), .held_kind(held_kind),
  .s_issue(s_issue), .s_commit(s_commit), .v_issue(v_issue), .v_commit(v_commit),
  .s_cnt(s_cnt), .v_cnt(v_cnt)
);

// File: tb/sim_mem_sync_ctrl.sv
`timescale 1ns/1ps
module sim_mem_sync_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       s_issue, s_commit, v_issue, v_commit, sync_req;
  logic [4:0] s_issue_vreg, s_commit_vreg, v_issue_vreg, v_commit_vreg, sync_vreg;
  logic [3:0] s_issue_tag, s_commit_tag, v_issue_tag, v_commit_tag;
  logic [2:0] sync_kind;
  logic       stall;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  mem_sync_ctrl u0 (
    .clk(clk), .rst(rst),
    .s_issue(s_issue), .s_issue_vreg(s_issue_vreg), .s_issue_tag(s_issue_tag),
    .s_commit(s_commit), .s_commit_vreg(s_commit_vreg), .s_commit_tag(s_commit_tag),
    .v_issue(v_issue), .v_issue_vreg(v_issue_vreg), .v_issue_tag(v_issue_tag),
    .v_commit(v_commit), .v_commit_vreg(v_commit_vreg), .v_commit_tag(v_commit_tag),
    .sync_req(sync_req), .sync_kind(sync_kind), .sync_vreg(sync_vreg),
    .stall(stall)
  );

  task automatic clear_in();
    s_issue = 0; s_commit = 0; v_issue = 0; v_commit = 0; sync_req = 0;
    s_issue_vreg = 0; s_commit_vreg = 0; v_issue_vreg = 0; v_commit_vreg = 0;
    s_issue_tag = 0; s_commit_tag = 0; v_issue_tag = 0; v_commit_tag = 0;
    sync_kind = 0; sync_vreg = 0;
  endtask

  // one clock: inputs set before the call are consumed at the rising edge
  task automatic cyc();
    @(negedge clk);
    clear_in();
  endtask

  task automatic chk(input string req, input logic exp);
    checks++;
    if (stall !== exp) begin
      errors++;
      $display("FAIL %s stall actual=%0b expected=%0b", req, stall, exp);
    end
  endtask

  task automatic vis(input int r, input int t);
    v_issue = 1; v_issue_vreg = 5'(r); v_issue_tag = 4'(t);
  endtask
  task automatic vcm(input int r, input int t);
    v_commit = 1; v_commit_vreg = 5'(r); v_commit_tag = 4'(t);
  endtask
  task automatic sis(input int r, input int t);
    s_issue = 1; s_issue_vreg = 5'(r); s_issue_tag = 4'(t);
  endtask
  task automatic scm(input int r, input int t);
    s_commit = 1; s_commit_vreg = 5'(r); s_commit_tag = 4'(t);
  endtask
  task automatic req(input int k, input int r);
    sync_req = 1; sync_kind = 3'(k); sync_vreg = 5'(r);
  endtask

  task automatic t_reset();
    chk("R1 idle after reset", 1'b0);
    req(0, 0); cyc(); chk("R1 R6 kind0 with empty vector count", 1'b0);
    req(1, 0); cyc(); chk("R1 R6 kind1 with empty scalar count", 1'b0);
    req(4, 17); cyc(); chk("R1 R6 kind4 with clear flag", 1'b0);
  endtask

  task automatic t_sav();
    for (int i = 0; i < 3; i++) begin vis(i, 1); cyc(); end
    req(0, 0); cyc(); chk("R3 stall raised", 1'b1);
    vcm(0, 1); cyc(); chk("R3 two left", 1'b1);
    vcm(1, 1); cyc(); chk("R3 one left", 1'b1);
    vcm(2, 1); cyc(); chk("R3 still high in drain cycle", 1'b1);
    cyc(); chk("R3 released", 1'b0);
  endtask

  task automatic t_vas();
    scm(0, 0); cyc(); scm(0, 0); cyc();
    sis(1, 1); cyc(); scm(1, 1); cyc();
    req(1, 0); cyc(); chk("R2 no underflow, kind1 free", 1'b0);
    sis(2, 2); cyc();
    sis(3, 3); scm(2, 2); cyc();
    req(1, 0); cyc(); chk("R4 stall raised", 1'b1);
    scm(3, 3); cyc(); chk("R4 high in drain cycle", 1'b1);
    cyc(); chk("R2 R4 balanced cycle left one op", 1'b0);
  endtask

  task automatic t_free();
    vis(6, 2); sis(8, 2); cyc();
    req(2, 0); cyc(); chk("R5 kind2 no stall", 1'b0);
    req(3, 0); cyc(); chk("R5 kind3 no stall", 1'b0);
    req(6, 0); cyc(); chk("R5 code6 no stall", 1'b0);
    req(7, 0); cyc(); chk("R5 code7 no stall", 1'b0);
    vcm(6, 2); scm(8, 2); cyc();
  endtask

  task automatic t_reg_sav();
    vis(5, 2); cyc(); vis(5, 3); cyc(); vis(9, 1); cyc(); vis(12, 0); cyc();
    req(4, 5); cyc(); chk("R7 stall on reg5", 1'b1);
    vcm(9, 1); cyc(); chk("R7 other reg commit no release", 1'b1);
    vcm(5, 2); cyc(); chk("R9 stale tag keeps flag", 1'b1);
    vcm(5, 3); cyc(); chk("R7 high in clear cycle", 1'b1);
    cyc(); chk("R7 released with reg12 outstanding", 1'b0);
    req(0, 0); cyc(); chk("R7 vector count still nonzero", 1'b1);
    vcm(12, 0); cyc(); cyc(); chk("R3 drain after reg test", 1'b0);
  endtask

  task automatic t_reg_vas();
    sis(7, 5); cyc();
    req(5, 3); cyc(); chk("R8 other reg free", 1'b0);
    req(5, 7); cyc(); chk("R8 stall on reg7", 1'b1);
    vis(7, 9); cyc(); chk("R8 vector op on reg7 irrelevant", 1'b1);
    scm(7, 5); cyc(); chk("R8 high in clear cycle", 1'b1);
    cyc(); chk("R8 released", 1'b0);
    vcm(7, 9); cyc();
  endtask

  task automatic t_busy();
    sis(1, 1); vis(2, 1); cyc();
    req(0, 0); cyc(); chk("R10 stall raised", 1'b1);
    req(1, 0); vis(3, 1); cyc(); chk("R10 issue during stall", 1'b1);
    vcm(2, 1); cyc(); chk("R10 issue lengthens wait", 1'b1);
    vcm(3, 1); cyc(); chk("R10 high in drain cycle", 1'b1);
    cyc(); chk("R10 ignored kind1 not taken", 1'b0);
    cyc(); chk("R10 stays low", 1'b0);
    scm(1, 1); cyc();
  endtask

  task automatic t_same_reg();
    vis(4, 1); cyc();
    vis(4, 2); vcm(4, 1); cyc();
    req(4, 4); cyc(); chk("R11 flag kept by same-cycle issue", 1'b1);
    vcm(4, 2); cyc(); cyc(); chk("R11 new tag clears", 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_in();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_sav();
    t_vas();
    t_free();
    t_reg_sav();
    t_reg_vas();
    t_busy();
    t_same_reg();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule